// File: doc/BRIEF.md
# Dual-Clock Dual-Port Burst RAM

A true dual-port static RAM of 16-bit words with a parameterized depth (2^AW words, AW up to 16). Its two ports, left and right, are fully independent and each runs on its own clock. On the rising edge of its clock a port captures its selects, its read/write direction, its byte selects and its write data. At the same edge it updates an address register that can clear to zero, advance as a burst counter, or take a new external address.

Each port picks its own read latency. In flow-through mode the data for an address follows the edge that registered that address. In pipelined mode the data is one edge later. The read bus is split into an upper and a lower byte lane. Each lane has a drive-enable output, and a lane that is not driven reads as zero. Drive is gated by an active-low output enable that acts at once, without waiting for a clock edge. Data written by one port can be read by the other port on any later edge of the reader's clock. If both ports write the same word in overlapping cycles, the stored result is undefined.

Top module: `dp_burst_ram`

## Requirements
- R1: A port acts only at an edge where its x_en0_n is 0 and its x_en1 is 1. At any other edge it writes nothing, and after that edge its lane enables are 00 in flow-through mode.
- R2: x_rd sampled at 1 makes the edge a read, and sampled at 0 makes it a write. It is captured at the same edge as the address.
- R3: x_hi_n (bits 15:8, enable bit 1) and x_lo_n (bits 7:0, enable bit 0) are active low. A write changes only the selected lanes. On a read, a deselected lane has its enable bit at 0 and its x_q lane at 0.
- R4: While x_outen_n is 1, x_lane_on is 00 and x_q is 0, without any clock edge. When it returns to 0, the read data reappears at once.
- R5: x_clr_n sampled at 0 sets the address register to 0, whatever x_inc_n and x_addr are.
- R6: When x_clr_n is 1 and x_inc_n is 0, the address register increments and x_addr is ignored. The register wraps from 2^AW-1 to 0.
- R7: When x_clr_n and x_inc_n are both 1, the address register loads x_addr.
- R8: A write stores into the word that the address register takes at that same edge, including a counted or cleared address.
- R9: With x_pipe at 0 (flow-through), read data and lane enables appear after the edge that registered the read.
- R10: With x_pipe at 1 (pipelined), read data and lane enables appear after the following edge and hold for one edge after the read ends.
- R11: A word written by one port is returned by the other port on a read registered on a later edge of the reader's clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left port clock |
| l_en0_n | input | 1 | Left select, active low |
| l_en1 | input | 1 | Left select, active high |
| l_rd | input | 1 | Left direction: 1 read, 0 write |
| l_hi_n | input | 1 | Left upper byte select, active low |
| l_lo_n | input | 1 | Left lower byte select, active low |
| l_outen_n | input | 1 | Left asynchronous output enable, active low |
| l_inc_n | input | 1 | Left counter increment, active low |
| l_clr_n | input | 1 | Left counter clear, active low |
| l_pipe | input | 1 | Left latency mode: 1 pipelined, 0 flow-through |
| l_addr | input | AW | Left external address |
| l_wd | input | 16 | Left write data |
| l_q | output | 16 | Left read data, zero on undriven lanes |
| l_lane_on | output | 2 | Left lane drive enables {upper, lower} |
| r_clk | input | 1 | Right port clock |
| r_en0_n | input | 1 | Right select, active low |
| r_en1 | input | 1 | Right select, active high |
| r_rd | input | 1 | Right direction: 1 read, 0 write |
| r_hi_n | input | 1 | Right upper byte select, active low |
| r_lo_n | input | 1 | Right lower byte select, active low |
| r_outen_n | input | 1 | Right asynchronous output enable, active low |
| r_inc_n | input | 1 | Right counter increment, active low |
| r_clr_n | input | 1 | Right counter clear, active low |
| r_pipe | input | 1 | Right latency mode: 1 pipelined, 0 flow-through |
| r_addr | input | AW | Right external address |
| r_wd | input | 16 | Right write data |
| r_q | output | 16 | Right read data, zero on undriven lanes |
| r_lane_on | output | 2 | Right lane drive enables {upper, lower} |

## Verification
A flow-through read is due right after the edge that registered it. A pipelined read is due after the next edge of the same clock. A change of the output enable is due with no edge at all. Stimulus is applied 2 ns after a rising edge. Each flow-through result is read in that same window, before the next edge. Pipelined results are read one period later, and output-enable results are read 1 ns after the enable toggles. The two clocks are offset by 7 ns, so a cross-port read is always registered on an edge after the writer's edge.

// File: rtl/dp_burst_ram.sv
module dp_burst_ram #(
  parameter int AW = 8,
  parameter int LW = 8
) (
  input  logic          l_clk,
  input  logic          l_en0_n,
  input  logic          l_en1,
  input  logic          l_rd,
  input  logic          l_hi_n,
  input  logic          l_lo_n,
  input  logic          l_outen_n,
  input  logic          l_inc_n,
  input  logic          l_clr_n,
  input  logic          l_pipe,
  input  logic [AW-1:0] l_addr,
  input  logic [2*LW-1:0] l_wd,
  output logic [2*LW-1:0] l_q,
  output logic [1:0]    l_lane_on,
  input  logic          r_clk,
  input  logic          r_en0_n,
  input  logic          r_en1,
  input  logic          r_rd,
  input  logic          r_hi_n,
  input  logic          r_lo_n,
  input  logic          r_outen_n,
  input  logic          r_inc_n,
  input  logic          r_clr_n,
  input  logic          r_pipe,
  input  logic [AW-1:0] r_addr,
  input  logic [2*LW-1:0] r_wd,
  output logic [2*LW-1:0] r_q,
  output logic [1:0]    r_lane_on
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = 2 * LW;

  logic [AW-1:0] la_q = '0, ra_q = '0;
  logic [AW-1:0] la_nx, ra_nx;
  logic          l_rd_q = 1'b0, r_rd_q = 1'b0;
  logic [1:0]    l_be_q = '0, r_be_q = '0, lp_en = '0, rp_en = '0;
  logic [DW-1:0] lp_d = '0, rp_d = '0;
  logic [DW-1:0] l_rdat, r_rdat;
  logic          l_live = 1'b0, r_live = 1'b0;

  wire       l_sel = !l_en0_n && l_en1;
  wire       r_sel = !r_en0_n && r_en1;
  wire       l_wr  = l_sel && !l_rd;
  wire       r_wr  = r_sel && !r_rd;
  wire [1:0] l_be  = ~{l_hi_n, l_lo_n};
  wire [1:0] r_be  = ~{r_hi_n, r_lo_n};

  assign la_nx = !l_clr_n ? '0 : (!l_inc_n ? la_q + 1'b1 : l_addr);
  assign ra_nx = !r_clr_n ? '0 : (!r_inc_n ? ra_q + 1'b1 : r_addr);

  always_ff @(posedge l_clk) begin
    l_live <= 1'b1;
    la_q   <= la_nx;
    l_rd_q <= l_sel && l_rd;
    l_be_q <= l_be;
    lp_d   <= l_rdat;
    lp_en  <= l_rd_q ? l_be_q : 2'b00;
  end

  always_ff @(posedge r_clk) begin
    r_live <= 1'b1;
    ra_q   <= ra_nx;
    r_rd_q <= r_sel && r_rd;
    r_be_q <= r_be;
    rp_d   <= r_rdat;
    rp_en  <= r_rd_q ? r_be_q : 2'b00;
  end

  wire [1:0]    l_on  = l_outen_n ? 2'b00 : (l_pipe ? lp_en : (l_rd_q ? l_be_q : 2'b00));
  wire [1:0]    r_on  = r_outen_n ? 2'b00 : (r_pipe ? rp_en : (r_rd_q ? r_be_q : 2'b00));
  wire [DW-1:0] l_src = l_pipe ? lp_d : l_rdat;
  wire [DW-1:0] r_src = r_pipe ? rp_d : r_rdat;

  assign l_lane_on = l_on;
  assign r_lane_on = r_on;

  // Each lane keeps one bank per port plus a toggle bit per word and port;
  // the XOR of the two toggles names the bank written last.
  for (genvar b = 0; b < 2; b++) begin : g_lane
    logic [LW-1:0]    bank_l [DEPTH];
    logic [LW-1:0]    bank_r [DEPTH];
    logic [DEPTH-1:0] tog_l = '0;
    logic [DEPTH-1:0] tog_r = '0;

    always_ff @(posedge l_clk)
      if (l_wr && l_be[b]) begin
        bank_l[la_nx] <= l_wd[b*LW +: LW];
        tog_l[la_nx]  <= tog_r[la_nx];
      end

    always_ff @(posedge r_clk)
      if (r_wr && r_be[b]) begin
        bank_r[ra_nx] <= r_wd[b*LW +: LW];
        tog_r[ra_nx]  <= ~tog_l[ra_nx];
      end

    assign l_rdat[b*LW +: LW] = (tog_l[la_q] ^ tog_r[la_q]) ? bank_r[la_q] : bank_l[la_q];
    assign r_rdat[b*LW +: LW] = (tog_l[ra_q] ^ tog_r[ra_q]) ? bank_r[ra_q] : bank_l[ra_q];
    assign l_q[b*LW +: LW]    = l_on[b] ? l_src[b*LW +: LW] : '0;
    assign r_q[b*LW +: LW]    = r_on[b] ? r_src[b*LW +: LW] : '0;
  end

  assert_l_clear_R5: assert property (@(posedge l_clk) disable iff (!l_live)
    !l_clr_n |=> la_q == '0);
  assert_l_count_R6: assert property (@(posedge l_clk) disable iff (!l_live)
    (l_clr_n && !l_inc_n) |=> la_q == $past(la_q) + 1'b1);
  assert_l_load_R7: assert property (@(posedge l_clk) disable iff (!l_live)
    (l_clr_n && l_inc_n) |=> la_q == $past(l_addr));
  assert_l_standby_R1: assert property (@(posedge l_clk) disable iff (!l_live)
    (!l_sel && !l_pipe) |=> (l_pipe || l_lane_on == 2'b00));

  assert_r_clear_R5: assert property (@(posedge r_clk) disable iff (!r_live)
    !r_clr_n |=> ra_q == '0);
  assert_r_count_R6: assert property (@(posedge r_clk) disable iff (!r_live)
    (r_clr_n && !r_inc_n) |=> ra_q == $past(ra_q) + 1'b1);
  assert_r_load_R7: assert property (@(posedge r_clk) disable iff (!r_live)
    (r_clr_n && r_inc_n) |=> ra_q == $past(r_addr));
  assert_r_standby_R1: assert property (@(posedge r_clk) disable iff (!r_live)
    (!r_sel && !r_pipe) |=> (r_pipe || r_lane_on == 2'b00));
endmodule

// File: tb/sim_dp_burst_ram.sv
`timescale 1ns/1ps
module sim_dp_burst_ram;
  logic l_clk = 1'b0, r_clk = 1'b0;
  logic l_en0_n, l_en1, l_rd, l_hi_n, l_lo_n, l_outen_n, l_inc_n, l_clr_n, l_pipe;
  logic r_en0_n, r_en1, r_rd, r_hi_n, r_lo_n, r_outen_n, r_inc_n, r_clr_n, r_pipe;
  logic [7:0]  l_addr, r_addr;
  logic [15:0] l_wd, r_wd, l_q, r_q;
  logic [1:0]  l_lane_on, r_lane_on;
  int checks = 0, errs = 0;
  bit done = 0;

  dp_burst_ram #(.AW(8), .LW(8)) u0 (
    .l_clk(l_clk), .l_en0_n(l_en0_n), .l_en1(l_en1), .l_rd(l_rd), .l_hi_n(l_hi_n),
    .l_lo_n(l_lo_n), .l_outen_n(l_outen_n), .l_inc_n(l_inc_n), .l_clr_n(l_clr_n),
    .l_pipe(l_pipe), .l_addr(l_addr), .l_wd(l_wd), .l_q(l_q), .l_lane_on(l_lane_on),
    .r_clk(r_clk), .r_en0_n(r_en0_n), .r_en1(r_en1), .r_rd(r_rd), .r_hi_n(r_hi_n),
    .r_lo_n(r_lo_n), .r_outen_n(r_outen_n), .r_inc_n(r_inc_n), .r_clr_n(r_clr_n),
    .r_pipe(r_pipe), .r_addr(r_addr), .r_wd(r_wd), .r_q(r_q), .r_lane_on(r_lane_on));

  always #10 l_clk = ~l_clk;
  initial begin #7; forever #10 r_clk = ~r_clk; end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic l_op(input logic e0n, input logic e1, input logic rd, input logic [1:0] bn,
                      input logic incn, input logic clrn, input logic [7:0] a, input logic [15:0] d);
    l_en0_n = e0n; l_en1 = e1; l_rd = rd; {l_hi_n, l_lo_n} = bn;
    l_inc_n = incn; l_clr_n = clrn; l_addr = a; l_wd = d;
    @(posedge l_clk); #2;
  endtask

  task automatic r_op(input logic e0n, input logic e1, input logic rd, input logic [1:0] bn,
                      input logic incn, input logic clrn, input logic [7:0] a, input logic [15:0] d);
    r_en0_n = e0n; r_en1 = e1; r_rd = rd; {r_hi_n, r_lo_n} = bn;
    r_inc_n = incn; r_clr_n = clrn; r_addr = a; r_wd = d;
    @(posedge r_clk); #2;
  endtask

  task automatic l_idle(); l_op(1, 0, 1, 2'b11, 1, 1, 8'h00, 16'h0); endtask
  task automatic r_idle(); r_op(1, 0, 1, 2'b11, 1, 1, 8'h00, 16'h0); endtask

  task automatic t_idle();
    l_idle(); l_idle(); r_idle(); r_idle();
    chk("R1 left idle lanes", {14'b0, l_lane_on}, 16'h0);
    chk("R1 left idle data", l_q, 16'h0);
    chk("R1 right idle lanes", {14'b0, r_lane_on}, 16'h0);
  endtask

  task automatic t_ft_rw();
    l_op(0, 1, 0, 2'b00, 1, 1, 8'h12, 16'hA55A);
    l_op(0, 1, 1, 2'b00, 1, 1, 8'h12, 16'h0);
    chk("R2 R9 flow-through read data", l_q, 16'hA55A);
    chk("R9 flow-through lanes", {14'b0, l_lane_on}, 16'h3);
  endtask

  task automatic t_bytes();
    l_op(0, 1, 0, 2'b01, 1, 1, 8'h12, 16'h3CC3);
    l_op(0, 1, 1, 2'b10, 1, 1, 8'h12, 16'h0);
    chk("R3 lower-only lanes", {14'b0, l_lane_on}, 16'h1);
    chk("R3 lower-only data", l_q, 16'h005A);
    l_op(0, 1, 1, 2'b00, 1, 1, 8'h12, 16'h0);
    chk("R3 upper-only write merged", l_q, 16'h3C5A);
  endtask

  task automatic t_oe();
    l_outen_n = 1'b1; #1;
    chk("R4 outen high data", l_q, 16'h0);
    chk("R4 outen high lanes", {14'b0, l_lane_on}, 16'h0);
    l_outen_n = 1'b0; #1;
    chk("R4 outen low data back", l_q, 16'h3C5A);
  endtask

  task automatic t_desel();
    l_op(0, 0, 0, 2'b00, 1, 1, 8'h12, 16'hFFFF);
    chk("R1 en1 low no drive", {14'b0, l_lane_on}, 16'h0);
    l_op(1, 1, 0, 2'b00, 1, 1, 8'h12, 16'hFFFF);
    l_op(0, 1, 1, 2'b00, 1, 1, 8'h12, 16'h0);
    chk("R1 deselected writes ignored", l_q, 16'h3C5A);
  endtask

  task automatic t_pipe();
    l_idle();
    l_pipe = 1'b1;
    l_op(0, 1, 1, 2'b00, 1, 1, 8'h12, 16'h0);
    chk("R10 pipelined not yet", {14'b0, l_lane_on}, 16'h0);
    l_op(0, 1, 1, 2'b00, 1, 1, 8'h12, 16'h0);
    chk("R10 pipelined data", l_q, 16'h3C5A);
    l_idle();
    chk("R10 pipelined tail lanes", {14'b0, l_lane_on}, 16'h3);
    l_idle();
    chk("R10 pipelined drained", {14'b0, l_lane_on}, 16'h0);
    l_pipe = 1'b0;
  endtask

  task automatic t_burst();
    l_op(0, 1, 0, 2'b00, 1, 1, 8'h40, 16'h1111);
    l_op(0, 1, 0, 2'b00, 0, 1, 8'hEE, 16'h2222);
    l_op(0, 1, 0, 2'b00, 0, 1, 8'hEE, 16'h3333);
    l_op(0, 1, 0, 2'b00, 0, 1, 8'hEE, 16'h4444);
    l_idle();
    r_op(0, 1, 1, 2'b00, 1, 1, 8'h40, 16'h0);
    chk("R7 R11 right load read", r_q, 16'h1111);
    r_op(0, 1, 1, 2'b00, 0, 1, 8'h05, 16'h0);
    chk("R6 R8 burst word 1", r_q, 16'h2222);
    r_op(0, 1, 1, 2'b00, 0, 1, 8'h05, 16'h0);
    chk("R6 R8 burst word 2", r_q, 16'h3333);
    r_op(0, 1, 1, 2'b00, 0, 1, 8'h05, 16'h0);
    chk("R6 R8 burst word 3", r_q, 16'h4444);
    r_idle();
  endtask

  task automatic t_wrap();
    l_op(0, 1, 0, 2'b00, 1, 1, 8'hFF, 16'h5A5A);
    l_op(0, 1, 0, 2'b00, 0, 1, 8'h10, 16'hA5A5);
    l_idle();
    r_op(0, 1, 1, 2'b00, 1, 1, 8'h00, 16'h0);
    chk("R6 wrap to zero", r_q, 16'hA5A5);
    r_op(0, 1, 1, 2'b00, 1, 1, 8'hFF, 16'h0);
    chk("R6 top word kept", r_q, 16'h5A5A);
    r_idle();
  endtask

  task automatic t_clear();
    r_op(0, 1, 0, 2'b00, 1, 1, 8'h77, 16'h7777);
    r_idle();
    l_op(0, 1, 0, 2'b00, 0, 0, 8'h77, 16'hBEEF);
    l_idle();
    r_op(0, 1, 1, 2'b00, 1, 1, 8'h00, 16'h0);
    chk("R5 cleared write to zero", r_q, 16'hBEEF);
    r_op(0, 1, 1, 2'b00, 1, 1, 8'h77, 16'h0);
    chk("R5 external address untouched", r_q, 16'h7777);
    r_idle();
    l_op(0, 1, 1, 2'b00, 0, 0, 8'h40, 16'h0);
    chk("R5 clear outranks count and address", l_q, 16'hBEEF);
    l_op(0, 1, 1, 2'b00, 1, 1, 8'h41, 16'h0);
    chk("R7 plain load", l_q, 16'h2222);
    l_idle();
  endtask

  task automatic t_cross();
    r_op(0, 1, 0, 2'b00, 1, 1, 8'h30, 16'h1357);
    r_idle();
    l_op(0, 1, 1, 2'b00, 1, 1, 8'h30, 16'h0);
    chk("R11 right to left", l_q, 16'h1357);
    l_idle();
    r_op(0, 1, 0, 2'b10, 1, 1, 8'h30, 16'h00AB);
    r_idle();
    l_op(0, 1, 1, 2'b00, 1, 1, 8'h30, 16'h0);
    chk("R3 R11 right lower-byte write", l_q, 16'h13AB);
    l_idle();
  endtask

  initial begin
    l_en0_n = 1; l_en1 = 0; l_rd = 1; l_hi_n = 1; l_lo_n = 1; l_outen_n = 0;
    l_inc_n = 1; l_clr_n = 1; l_pipe = 0; l_addr = '0; l_wd = '0;
    r_en0_n = 1; r_en1 = 0; r_rd = 1; r_hi_n = 1; r_lo_n = 1; r_outen_n = 0;
    r_inc_n = 1; r_clr_n = 1; r_pipe = 0; r_addr = '0; r_wd = '0;
    t_idle();
    t_ft_rw();
    t_bytes();
    t_oe();
    t_desel();
    t_pipe();
    t_burst();
    t_wrap();
    t_clear();
    t_cross();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule